// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a 32-bit virtual address into a physical address by walking a tree of in-memory descriptors. A request carries the virtual address and an access kind (read, write or instruction fetch). The walker reads a context entry first, then one descriptor per level through a single read port with a valid/ready handshake. The walk can end at the first, second or third level, which maps a 16 MB, 256 KB or 4 KB page. When the walk ends, the block gives either a physical address with a page-size code, or a ten-bit fault word. The fault word holds the level at which the walk stopped and the kind of failure.

On a successful walk the block keeps the referenced and modified flags of the final entry up to date. It writes the entry back through a separate write port, but only when one of those flags actually changes. Decoding of permissions is left to the consumer: the raw three-bit access field of the final entry is passed on as it is. Write permission is reported only once the entry is marked modified, so the first write to a clean page always comes back through the walker. With translation switched off, the address goes straight through. With boot mode also on, fetches are steered into a boot ROM window.

Top module: `ptw_walker`

## Requirements
- R1: The first read of a translated walk targets `ctx_ptr * 16 + ctx_num * 4`, using the register values present when the request is accepted.
- R2: A descriptor's type is its bits [1:0] (0 invalid, 1 pointer, 2 page entry, 3 reserved). A pointer at the context level or at level 1 or 2 leads to a read at `{desc[31:2],2'b00} * 16 + index * 4`. The index is VA[31:24] for level 1, VA[23:18] for level 2 and VA[17:12] for level 3.
- R3: A page entry at level 1, 2 or 3 ends the walk with `done_size` 2 (16 MB), 1 (256 KB) or 0 (4 KB). `done_pa` is `entry[31:8] * 4096`, plus the VA bits between bit 12 and the level's index field, ORed with VA[11:0].
- R4: A failed walk gives `done_fault`=1 and `done_err = level*256 + kind*4`. The level is 0 for context and 1 to 3 for the tables. The kind is 1 for an invalid descriptor and 4 for a reserved one. A page entry at the context level and a pointer at level 3 also give kind 4.
- R5: With `ctl_enable`=0, the walker makes no memory access and returns `done_pa` equal to the VA, with `done_bypass`=1 and `done_wr_ok`=1.
- R6: With `ctl_enable`=0 and `ctl_boot`=1, a fetch (`req_acc`=2) returns `prom_base | VA[18:0]` with `done_wr_ok`=0. Reads and writes are not redirected.
- R7: On success, bit 5 of the final entry is set, and on a write (`req_acc`=1) bit 6 is set too. The updated entry is written to the address that the entry was read from, before `done` rises.
- R8: No write-back happens when bits 5 and 6 already hold the values of R7.
- R9: `done_wr_ok` equals bit 6 of the final entry after the update, and it is 0 on any fault.
- R10: `done_acc` carries bits [4:2] of the final entry unchanged.
- R11: `req_ready` is high only when the walker is idle. `done` is a single-cycle pulse, and `req_ready` is low in the cycle after an accepted request.
- R12: A read request stays asserted with a stable address until it is accepted. Only one read is outstanding at a time, and a read and a write never overlap. Results are unaffected by stalls of the ready signals.
- R13: A synchronous reset returns the walker to idle with `req_ready`=1, `done`=0 and no pending write, even in the middle of a write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken on this cycle |
| req_va | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| ctl_enable | input | 1 | Translation enable |
| ctl_boot | input | 1 | Boot mode, redirects fetches while translation is off |
| ctx_ptr | input | 32 | Context table pointer (byte address / 16) |
| ctx_num | input | CTX_W | Context number |
| prom_base | input | PA_W | Boot ROM window base |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | PA_W | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| mem_wr_valid | output | 1 | Descriptor write-back request |
| mem_wr_ready | input | 1 | Write accepted |
| mem_wr_addr | output | PA_W | Write-back byte address |
| mem_wr_data | output | 32 | Updated descriptor |
| done | output | 1 | One-cycle result pulse |
| done_fault | output | 1 | Walk failed |
| done_err | output | 10 | Fault word |
| done_pa | output | PA_W | Physical address |
| done_size | output | 2 | Page size code |
| done_acc | output | 3 | Raw access field of the final entry |
| done_wr_ok | output | 1 | Writes may be mapped |
| done_bypass | output | 1 | Result came from untranslated mode |

## Verification
A wrong level counter or a wrong next-address register shows up on the very next read request. That request goes to a descriptor address that differs from the one computed from the VA index fields, and the scoreboard then sees a wrong fault level or a wrong physical address at the same `done` pulse. A wrong flag update shows at the write port before `done`. A missing or extra write changes the memory image that the bench inspects at the pulse. It also changes the outcome of the next access to the same page, so it shows within one further request. A stuck state appears within a few cycles as a missing `done` or as `req_ready` staying low.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_CTX  = 3'd1,
      ST_L1   = 3'd2,
      ST_L2   = 3'd3,
      ST_L3   = 3'd4,
      ST_WB   = 3'd5,
      ST_DONE = 3'd6
   } walk_state_t;

   localparam logic [1:0] ACC_READ  = 2'd0;
   localparam logic [1:0] ACC_WRITE = 2'd1;
   localparam logic [1:0] ACC_FETCH = 2'd2;

   localparam logic [1:0] DT_INVALID = 2'd0;
   localparam logic [1:0] DT_PTR     = 2'd1;
   localparam logic [1:0] DT_PAGE    = 2'd2;
   localparam logic [1:0] DT_RSVD    = 2'd3;

   localparam logic [2:0] FK_INVALID = 3'd1;
   localparam logic [2:0] FK_XLATE   = 3'd4;

   localparam logic [1:0] SZ_4K   = 2'd0;
   localparam logic [1:0] SZ_256K = 2'd1;
   localparam logic [1:0] SZ_16M  = 2'd2;

   localparam int ERR_W     = 10;
   localparam int REF_BIT   = 5;
   localparam int MOD_BIT   = 6;
   localparam int BOOT_BITS = 19;
   localparam int PAGE_LSB  = 12;

   // low bit of the table index used at each level (1..3)
   function automatic int idx_lo(input int lvl);
      return (lvl == 1) ? 24 : (lvl == 2) ? 18 : 12;
   endfunction

   function automatic logic [ERR_W-1:0] fault_word(input logic [1:0] lvl,
                                                   input logic [2:0] kind);
      return {lvl, 3'b000, kind, 2'b00};
   endfunction

endpackage

// File: rtl/ptw_desc_addr.sv
module ptw_desc_addr
   import ptw_pkg::*;
#(
   parameter int PA_W  = 36,
   parameter int CTX_W = 8
) (
   input  logic [1:0]       lvl,
   input  logic [31:0]      ctx_ptr,
   input  logic [CTX_W-1:0] ctx_num,
   input  logic [31:0]      va,
   input  logic [31:0]      ptr_desc,
   output logic [PA_W-1:0]  addr
);
   localparam int L1_LO = idx_lo(1);
   localparam int L2_LO = idx_lo(2);
   localparam int L3_LO = idx_lo(3);
   localparam int IDX_W = 32 - L1_LO;

   logic [PA_W-1:0]  ctx_base;
   logic [PA_W-1:0]  tbl_base;
   logic [IDX_W-1:0] idx;

   always_comb begin
      ctx_base = (PA_W'(ctx_ptr) << 4) + (PA_W'(ctx_num) << 2);
      tbl_base = PA_W'({ptr_desc[31:2], 2'b00}) << 4;
      case (lvl)
         2'd1:    idx = va[31:L1_LO];
         2'd2:    idx = IDX_W'(va[L1_LO-1:L2_LO]);
         2'd3:    idx = IDX_W'(va[L2_LO-1:L3_LO]);
         default: idx = '0;
      endcase
      addr = (lvl == 2'd0) ? ctx_base : tbl_base + (PA_W'(idx) << 2);
   end

endmodule

// File: rtl/ptw_finalize.sv
module ptw_finalize
   import ptw_pkg::*;
#(
   parameter int PA_W = 36
) (
   input  logic [31:0]     entry,
   input  logic [1:0]      lvl,
   input  logic [31:0]     va,
   input  logic            is_write,
   output logic [31:0]     new_entry,
   output logic            need_wb,
   output logic [PA_W-1:0] pa,
   output logic [1:0]      size,
   output logic [2:0]      acc_field,
   output logic            wr_ok
);
   logic [31:0] lvl_off [1:3];

   for (genvar k = 1; k <= 3; k++) begin : g_lvl
      localparam int LO = idx_lo(k);
      if (LO > PAGE_LSB) begin : g_span
         assign lvl_off[k] = {{(32-LO){1'b0}}, va[LO-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
      end else begin : g_none
         assign lvl_off[k] = '0;
      end
   end

   logic [31:0] off_sel;

   always_comb begin
      new_entry = entry;
      new_entry[REF_BIT] = 1'b1;
      if (is_write) new_entry[MOD_BIT] = 1'b1;
      need_wb = (new_entry != entry);
      case (lvl)
         2'd1:    begin off_sel = lvl_off[1]; size = SZ_16M;  end
         2'd2:    begin off_sel = lvl_off[2]; size = SZ_256K; end
         default: begin off_sel = lvl_off[3]; size = SZ_4K;   end
      endcase
      pa = ((PA_W'(entry[31:8]) << PAGE_LSB) + PA_W'(off_sel)) | PA_W'(va[PAGE_LSB-1:0]);
      acc_field = entry[4:2];
      wr_ok     = new_entry[MOD_BIT];
   end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int PA_W  = 36,
   parameter int CTX_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [31:0]       req_va,
   input  logic [1:0]        req_acc,
   input  logic              ctl_enable,
   input  logic              ctl_boot,
   input  logic [31:0]       ctx_ptr,
   input  logic [CTX_W-1:0]  ctx_num,
   input  logic [PA_W-1:0]   prom_base,
   output logic              mem_rd_valid,
   input  logic              mem_rd_ready,
   output logic [PA_W-1:0]   mem_rd_addr,
   input  logic              mem_rsp_valid,
   input  logic [31:0]       mem_rsp_data,
   output logic              mem_wr_valid,
   input  logic              mem_wr_ready,
   output logic [PA_W-1:0]   mem_wr_addr,
   output logic [31:0]       mem_wr_data,
   output logic              done,
   output logic              done_fault,
   output logic [ERR_W-1:0]  done_err,
   output logic [PA_W-1:0]   done_pa,
   output logic [1:0]        done_size,
   output logic [2:0]        done_acc,
   output logic              done_wr_ok,
   output logic              done_bypass
);
   localparam int MIN_PA_W = 24 + PAGE_LSB;

   if (PA_W < MIN_PA_W) begin : g_pa_check
      initial $fatal(1, "ptw_walker: PA_W must be at least %0d", MIN_PA_W);
   end
   if (CTX_W < 1 || CTX_W > 30) begin : g_ctx_check
      initial $fatal(1, "ptw_walker: CTX_W out of range");
   end

   walk_state_t      state;
   logic             rd_pend;
   logic [PA_W-1:0]  cur_addr;
   logic [31:0]      va_q;
   logic [1:0]       acc_q;
   logic [31:0]      wb_data;

   logic             r_fault;
   logic [ERR_W-1:0] r_err;
   logic [PA_W-1:0]  r_pa;
   logic [1:0]       r_size;
   logic [2:0]       r_acc;
   logic             r_wr_ok;
   logic             r_bypass;

   logic [1:0]       cur_lvl;
   logic [1:0]       gen_lvl;
   logic             walking;
   logic [PA_W-1:0]  gen_addr;
   logic [31:0]      fin_entry;
   logic             fin_wb;
   logic [PA_W-1:0]  fin_pa;
   logic [1:0]       fin_size;
   logic [2:0]       fin_acc;
   logic             fin_wr_ok;
   logic [PA_W-1:0]  bypass_pa;
   logic             boot_fetch;

   always_comb begin
      walking = 1'b1;
      case (state)
         ST_CTX:  cur_lvl = 2'd0;
         ST_L1:   cur_lvl = 2'd1;
         ST_L2:   cur_lvl = 2'd2;
         ST_L3:   cur_lvl = 2'd3;
         default: begin cur_lvl = 2'd0; walking = 1'b0; end
      endcase
      gen_lvl    = (state == ST_IDLE) ? 2'd0 : cur_lvl + 2'd1;
      boot_fetch = ctl_boot && (req_acc == ACC_FETCH);
      bypass_pa  = boot_fetch ? (prom_base | PA_W'(req_va[BOOT_BITS-1:0]))
                              : PA_W'(req_va);
   end

   ptw_desc_addr #(.PA_W(PA_W), .CTX_W(CTX_W)) u_addr (
      .lvl      (gen_lvl),
      .ctx_ptr  (ctx_ptr),
      .ctx_num  (ctx_num),
      .va       (va_q),
      .ptr_desc (mem_rsp_data),
      .addr     (gen_addr)
   );

   ptw_finalize #(.PA_W(PA_W)) u_fin (
      .entry     (mem_rsp_data),
      .lvl       (cur_lvl),
      .va        (va_q),
      .is_write  (acc_q == ACC_WRITE),
      .new_entry (fin_entry),
      .need_wb   (fin_wb),
      .pa        (fin_pa),
      .size      (fin_size),
      .acc_field (fin_acc),
      .wr_ok     (fin_wr_ok)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         rd_pend  <= 1'b0;
         cur_addr <= '0;
         va_q     <= '0;
         acc_q    <= ACC_READ;
         wb_data  <= '0;
         r_fault  <= 1'b0;
         r_err    <= '0;
         r_pa     <= '0;
         r_size   <= SZ_4K;
         r_acc    <= '0;
         r_wr_ok  <= 1'b0;
         r_bypass <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q  <= req_va;
                  acc_q <= req_acc;
                  if (!ctl_enable) begin
                     r_fault  <= 1'b0;
                     r_err    <= '0;
                     r_pa     <= bypass_pa;
                     r_size   <= SZ_4K;
                     r_acc    <= '0;
                     r_wr_ok  <= !boot_fetch;
                     r_bypass <= 1'b1;
                     state    <= ST_DONE;
                  end else begin
                     cur_addr <= gen_addr;
                     rd_pend  <= 1'b0;
                     r_bypass <= 1'b0;
                     state    <= ST_CTX;
                  end
               end
            end
            ST_CTX, ST_L1, ST_L2, ST_L3: begin
               if (!rd_pend) begin
                  if (mem_rd_ready) rd_pend <= 1'b1;
               end else if (mem_rsp_valid) begin
                  rd_pend <= 1'b0;
                  r_pa    <= '0;
                  r_wr_ok <= 1'b0;
                  r_acc   <= '0;
                  r_size  <= SZ_4K;
                  case (mem_rsp_data[1:0])
                     DT_PTR: begin
                        if (state == ST_L3) begin
                           r_fault <= 1'b1;
                           r_err   <= fault_word(cur_lvl, FK_XLATE);
                           state   <= ST_DONE;
                        end else begin
                           cur_addr <= gen_addr;
                           state    <= walk_state_t'(state + 3'd1);
                        end
                     end
                     DT_PAGE: begin
                        if (state == ST_CTX) begin
                           r_fault <= 1'b1;
                           r_err   <= fault_word(cur_lvl, FK_XLATE);
                           state   <= ST_DONE;
                        end else begin
                           r_fault <= 1'b0;
                           r_err   <= '0;
                           r_pa    <= fin_pa;
                           r_size  <= fin_size;
                           r_acc   <= fin_acc;
                           r_wr_ok <= fin_wr_ok;
                           wb_data <= fin_entry;
                           state   <= fin_wb ? ST_WB : ST_DONE;
                        end
                     end
                     DT_INVALID: begin
                        r_fault <= 1'b1;
                        r_err   <= fault_word(cur_lvl, FK_INVALID);
                        state   <= ST_DONE;
                     end
                     default: begin
                        r_fault <= 1'b1;
                        r_err   <= fault_word(cur_lvl, FK_XLATE);
                        state   <= ST_DONE;
                     end
                  endcase
               end
            end
            ST_WB: begin
               if (mem_wr_ready) state <= ST_DONE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready    = (state == ST_IDLE);
   assign mem_rd_valid = walking && !rd_pend;
   assign mem_rd_addr  = cur_addr;
   assign mem_wr_valid = (state == ST_WB);
   assign mem_wr_addr  = cur_addr;
   assign mem_wr_data  = wb_data;
   assign done         = (state == ST_DONE);
   assign done_fault   = r_fault;
   assign done_err     = r_err;
   assign done_pa      = r_pa;
   assign done_size    = r_size;
   assign done_acc     = r_acc;
   assign done_wr_ok   = r_wr_ok;
   assign done_bypass  = r_bypass;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
   import ptw_pkg::*;
#(
   parameter int PA_W  = 36,
   parameter int CTX_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              req_ready,
   input logic              mem_rd_valid,
   input logic              mem_rd_ready,
   input logic [PA_W-1:0]   mem_rd_addr,
   input logic              mem_wr_valid,
   input logic              mem_wr_ready,
   input logic [31:0]       mem_wr_data,
   input logic              done,
   input logic              done_fault,
   input logic              done_wr_ok
);
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
      mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr)); // R12
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
      mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_data)); // R7
   AST_PORT_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd_valid && mem_wr_valid)); // R12
   AST_WB_REF_SET: assert property (@(posedge clk) disable iff (rst)
      mem_wr_valid |-> mem_wr_data[REF_BIT]); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R11
   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
      req_valid && req_ready |=> !req_ready); // R11
   AST_READ_NOT_IDLE: assert property (@(posedge clk) disable iff (rst)
      mem_rd_valid |-> !req_ready); // R11
   AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      done && done_fault |-> !done_wr_ok); // R9
   AST_RESET_IDLE: assert property (@(posedge clk)
      $past(rst) |-> req_ready && !mem_wr_valid && !done); // R13
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W), .CTX_W(CTX_W)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .mem_rd_valid (mem_rd_valid),
   .mem_rd_ready (mem_rd_ready),
   .mem_rd_addr  (mem_rd_addr),
   .mem_wr_valid (mem_wr_valid),
   .mem_wr_ready (mem_wr_ready),
   .mem_wr_data  (mem_wr_data),
   .done         (done),
   .done_fault   (done_fault),
   .done_wr_ok   (done_wr_ok)
);

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
   localparam int PA_W  = 36;
   localparam int CTX_W = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [31:0]       req_va = '0;
   logic [1:0]        req_acc = '0;
   logic              ctl_enable = 1'b0;
   logic              ctl_boot = 1'b0;
   logic [31:0]       ctx_ptr = 32'h0010_0000;
   logic [CTX_W-1:0]  ctx_num = 8'd3;
   logic [PA_W-1:0]   prom_base = 36'h0_FF00_0000;
   logic              mem_rd_valid;
   logic              mem_rd_ready = 1'b0;
   logic [PA_W-1:0]   mem_rd_addr;
   logic              mem_rsp_valid = 1'b0;
   logic [31:0]       mem_rsp_data = '0;
   logic              mem_wr_valid;
   logic              mem_wr_ready = 1'b0;
   logic [PA_W-1:0]   mem_wr_addr;
   logic [31:0]       mem_wr_data;
   logic              done;
   logic              done_fault;
   logic [9:0]        done_err;
   logic [PA_W-1:0]   done_pa;
   logic [1:0]        done_size;
   logic [2:0]        done_acc;
   logic              done_wr_ok;
   logic              done_bypass;

   ptw_walker #(.PA_W(PA_W), .CTX_W(CTX_W)) uut (.*);

   int n_chk  = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [31:0] mem [logic [PA_W-1:0]];
   bit          rd_stall = 0;
   bit          wr_hold  = 0;
   bit          pend = 0;
   logic [PA_W-1:0] pend_addr;
   int          wr_cnt = 0;
   int          cyc = 0;

   function automatic logic [31:0] rdm(input logic [PA_W-1:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         mem_rsp_valid = 1'b0;
         if (rst) pend = 0;
         if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = rdm(pend_addr);
            pend = 0;
         end
         mem_rd_ready = !rd_stall || (cyc % 3 == 0);
         mem_wr_ready = !wr_hold && (!rd_stall || (cyc % 2 == 0));
         if (!rst && mem_rd_valid && mem_rd_ready) begin
            pend = 1;
            pend_addr = mem_rd_addr;
         end
         if (!rst && mem_wr_valid && mem_wr_ready) begin
            mem[mem_wr_addr] = mem_wr_data;
            wr_cnt++;
         end
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      string           tag;
      bit              fault;
      logic [9:0]      err;
      logic [PA_W-1:0] pa;
      logic [1:0]      size;
      logic [2:0]      acc;
      bit              wr_ok;
      bit              bypass;
      bit              wb;
      logic [PA_W-1:0] wb_addr;
      logic [31:0]     wb_data;
      int              wr_base;
   } exp_t;

   exp_t sb[$];

   // expected result straight from the requirements
   function automatic exp_t predict(input logic [31:0] va, input logic [1:0] acc, input string tag);
      exp_t e;
      logic [PA_W-1:0] a;
      logic [31:0] d, nd;
      int lvl;
      bit fin;
      e = '{tag: tag, fault: 0, err: 0, pa: 0, size: 0, acc: 0, wr_ok: 0,
            bypass: 0, wb: 0, wb_addr: 0, wb_data: 0, wr_base: wr_cnt};
      if (!ctl_enable) begin                                     // R5 / R6
         e.bypass = 1;
         if (ctl_boot && acc == 2'd2) begin
            e.pa = prom_base | {17'h0, va[18:0]};
            e.wr_ok = 0;
         end else begin
            e.pa = {4'h0, va};
            e.wr_ok = 1;
         end
         return e;
      end
      a = ({4'h0, ctx_ptr} << 4) + {26'h0, ctx_num, 2'b00};    // R1
      lvl = 0;
      fin = 0;
      while (!fin) begin
         d = rdm(a);
         fin = 1;
         if (d[1:0] == 2'd0) begin
            e.fault = 1; e.err = 10'(lvl * 256 + 4);
         end else if (d[1:0] == 2'd3 || (d[1:0] == 2'd2 && lvl == 0) ||
                      (d[1:0] == 2'd1 && lvl == 3)) begin
            e.fault = 1; e.err = 10'(lvl * 256 + 16);
         end else if (d[1:0] == 2'd1) begin                      // R2
            lvl++;
            a = {4'h0, d[31:2], 2'b00} << 4;
            if (lvl == 1) a = a + (PA_W'(va[31:24]) * 4);
            else if (lvl == 2) a = a + (PA_W'(va[23:18]) * 4);
            else a = a + (PA_W'(va[17:12]) * 4);
            fin = 0;
         end else begin                                         // R3, R7-R10
            nd = d | 32'h20 | ((acc == 2'd1) ? 32'h40 : 32'h0);
            e.wb = (nd != d);
            e.wb_addr = a;
            e.wb_data = nd;
            e.wr_ok = nd[6];
            e.acc = d[4:2];
            e.pa = PA_W'(d[31:8]) * 4096;
            if (lvl == 1) begin e.size = 2; e.pa = e.pa + PA_W'(va[23:12]) * 4096; end
            else if (lvl == 2) begin e.size = 1; e.pa = e.pa + PA_W'(va[17:12]) * 4096; end
            else e.size = 0;
            e.pa = e.pa | PA_W'(va[11:0]);
         end
      end
      return e;
   endfunction

   initial begin
      forever begin
         @(negedge clk);
         if (done) begin
            if (sb.size() == 0) begin
               chk(0, "R11", "unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(done_fault == e.fault, e.tag, "fault flag", done_fault, e.fault);
               chk(done_wr_ok == e.wr_ok, e.tag, "wr_ok", done_wr_ok, e.wr_ok);
               if (e.fault) begin
                  chk(done_err == e.err, e.tag, "fault word", done_err, e.err);
               end else begin
                  chk(done_pa == e.pa, e.tag, "pa", done_pa, e.pa);
                  chk(done_bypass == e.bypass, e.tag, "bypass", done_bypass, e.bypass);
                  if (!e.bypass) begin
                     chk(done_size == e.size, e.tag, "size", done_size, e.size);
                     chk(done_acc == e.acc, e.tag, "acc field", done_acc, e.acc);
                  end
               end
               chk((wr_cnt - e.wr_base) == int'(e.wb), e.tag, "writeback count",
                   wr_cnt - e.wr_base, e.wb);
               if (e.wb)
                  chk(rdm(e.wb_addr) == e.wb_data, e.tag, "writeback data",
                      rdm(e.wb_addr), e.wb_data);
            end
         end
      end
   end

   // ---------------- driver ----------------
   task automatic walk(input logic [31:0] va, input logic [1:0] acc, input string tag);
      exp_t e;
      logic [PA_W-1:0] ctx_addr;
      e = predict(va, acc, tag);
      sb.push_back(e);
      ctx_addr = ({4'h0, ctx_ptr} << 4) + {26'h0, ctx_num, 2'b00};
      @(negedge clk);
      req_valid = 1'b1;
      req_va    = va;
      req_acc   = acc;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R11", "ready after accept", req_ready, 0);
      if (ctl_enable) begin
         chk(mem_rd_valid && mem_rd_addr == ctx_addr, "R1", "context read address",
             mem_rd_addr, ctx_addr);
      end else begin
         chk(!mem_rd_valid, "R5", "no read when bypassed", mem_rd_valid, 0);
      end
      while (sb.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   bit finished = 0;
   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      // tables: context at 0x100_0000, L1 at 0x200_0000, L2 at 0x300_0000 / 0x310_0000, L3 at 0x400_0000
      mem[36'h0100_000C] = 32'h0020_0001;   // ctx 3 -> L1
      mem[36'h0100_0010] = 32'h0000_0000;   // ctx 4 invalid
      mem[36'h0100_0014] = 32'h0000_0012;   // ctx 5 page entry
      mem[36'h0100_0018] = 32'h0000_0003;   // ctx 6 reserved
      mem[36'h0200_0014] = 32'h1230_0066;   // L1[5] 16MB page, ref+mod set
      mem[36'h0200_0018] = 32'h0030_0001;   // L1[6] -> L2
      mem[36'h0200_001C] = 32'h0000_0000;   // L1[7] invalid
      mem[36'h0200_0020] = 32'h0000_0003;   // L1[8] reserved
      mem[36'h0200_0024] = 32'h0031_0001;   // L1[9] -> L2b
      mem[36'h0200_0028] = 32'h0450_0012;   // L1[10] 16MB page, clean
      mem[36'h0300_0008] = 32'h0ABC_0002;   // L2[2] 256KB page, clean
      mem[36'h0300_000C] = 32'h0040_0001;   // L2[3] -> L3
      mem[36'h0310_0004] = 32'h0000_0003;   // L2b[1] reserved
      mem[36'h0400_0004] = 32'h0F00_0A1E;   // L3[1] 4KB page, clean
      mem[36'h0400_000C] = 32'h0000_0001;   // L3[3] pointer
      mem[36'h0400_0010] = 32'h0000_0003;   // L3[4] reserved

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R13 state right after reset
      chk(req_ready == 1'b1, "R13", "ready after reset", req_ready, 1);
      chk(done == 1'b0, "R13", "done after reset", done, 0);
      chk(mem_wr_valid == 1'b0, "R13", "no write after reset", mem_wr_valid, 0);
      chk(mem_rd_valid == 1'b0, "R13", "no read after reset", mem_rd_valid, 0);

      // R5 / R6 untranslated
      ctl_enable = 0; ctl_boot = 0;
      walk(32'h1234_5678, 2'd0, "R5");
      walk(32'hDEAD_B000, 2'd2, "R5");
      ctl_boot = 1;
      walk(32'h0007_ABCD, 2'd2, "R6");
      walk(32'h0007_ABCD, 2'd1, "R6");

      // translated walks
      ctl_enable = 1; ctl_boot = 0;
      walk(32'h05AB_C123, 2'd0, "R3");       // 16MB page, no write-back (R8)
      walk(32'h05AB_C123, 2'd1, "R8");
      walk(32'h0608_5ABC, 2'd0, "R7");       // 256KB page, ref set, wr_ok 0 (R9)
      walk(32'h0608_5ABC, 2'd0, "R8");
      walk(32'h0608_5ABC, 2'd1, "R9");       // now modified
      walk(32'h060C_1234, 2'd1, "R2");       // 4KB page via three pointers, write (R7, R10)
      walk(32'h060C_1234, 2'd0, "R10");
      // faults
      walk(32'h0700_0000, 2'd0, "R4");
      walk(32'h0800_0000, 2'd0, "R4");
      walk(32'h0900_0000, 2'd0, "R4");
      walk(32'h0904_0000, 2'd1, "R4");
      walk(32'h060C_2000, 2'd0, "R4");
      walk(32'h060C_3000, 2'd2, "R4");
      walk(32'h060C_4000, 2'd0, "R4");
      ctx_num = 8'd4; walk(32'h0500_0000, 2'd0, "R4");
      ctx_num = 8'd5; walk(32'h0500_0000, 2'd0, "R4");
      ctx_num = 8'd6; walk(32'h0500_0000, 2'd2, "R4");
      ctx_num = 8'd3;

      // R12 stalled handshakes
      rd_stall = 1;
      walk(32'h060C_1FFF, 2'd2, "R12");
      walk(32'h0600_0000, 2'd0, "R12");
      walk(32'h0A12_3456, 2'd0, "R12");      // clean 16MB, ref write-back under stall
      rd_stall = 0;

      // R13 reset in the middle of a write-back
      wr_hold = 1;
      @(negedge clk);
      req_valid = 1'b1; req_va = 32'h0A00_0010; req_acc = 2'd1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!mem_wr_valid) @(negedge clk);
      chk(mem_wr_valid == 1'b1, "R13", "write-back pending before reset", mem_wr_valid, 1);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      chk(mem_wr_valid == 1'b0, "R13", "write dropped by reset", mem_wr_valid, 0);
      chk(req_ready == 1'b1, "R13", "idle after reset", req_ready, 1);
      chk(rdm(36'h0200_0028) == 32'h0450_0032, "R13", "entry untouched by aborted write",
          rdm(36'h0200_0028), 32'h0450_0032);
      wr_hold = 0;
      walk(32'h0A00_0010, 2'd1, "R13");      // walks again and sets modified

      repeat (4) @(negedge clk);
      chk(sb.size() == 0, "R11", "all results delivered", sb.size(), 0);
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule